// File: doc/BRIEF.md
# Single-Channel Low-Power PWM Timer

The block is a one-output pulse-width modulator controlled through a small word-wide register bank. A selectable power-of-two prescaler produces count ticks. An up-counter steps from zero to a reload limit and then wraps. The output is active while the counter is above a compare threshold, and a polarity bit picks which level counts as active.

Software drives it through a write strobe with an address and data word. Read data is registered and appears one cycle after the address is presented. The rules for accepting a write depend on the enable state. The prescaler and polarity can only be changed while the timer is disabled. The reload and compare limits are only accepted while it is enabled.

Each accepted limit write is confirmed by a sticky flag in the status word. The flag rises after a fixed synchronisation delay and is cleared by writing ones to a separate clear word. New limits are staged and take effect only at the counter wrap, so a running period is never cut short.

Top module: `lpt_pwm_timer`

## Requirements
- R1: After reset, pwm_out is 0, reload reads 0xFFFF, compare reads 0, and config, control and status read 0.
- R2: While running with prescale select N, one output period lasts (reload+1)·2^N clock cycles, and the counter never exceeds the active reload value.
- R3: A write to the config word (address 1: bits 2:0 prescale select N, bit 3 polarity) is ignored while the enable bit is set.
- R4: Writes to reload (address 2) and compare (address 3) are ignored while the enable bit is clear.
- R5: When compare < reload, each period holds the active level for (reload−compare)·2^N cycles. When compare ≥ reload, the active level never appears.
- R6: An accepted reload or compare write clears its OK flag. The status word (address 4: bit 0 compare OK, bit 1 reload OK) shows the flag set exactly 3 cycles after the write edge, which is the 4th registered read after it.
- R7: Writing 1 to bit 0 or bit 1 of the clear word (address 5) clears the compare OK or reload OK flag respectively. A flag that is being set in the same cycle stays set.
- R8: In the control word (address 0: bit 0 enable, bit 1 start), start begins counting only if enable was already set before the write. Writing 0 stops and disables the timer. Reading the control word returns {running, enable} in bits 1:0.
- R9: Polarity 1 inverts the output. While the timer is not running, pwm_out holds the inactive level, equal to the polarity bit.
- R10: Reload and compare values written while running take effect only at the next counter wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data for addr |
| pwm_out | output | 1 | Registered PWM waveform |

## Verification
The bench writes a new reload value in the middle of a long first period and counts the active cycles in that period. A design that loads limits immediately would shorten the period and lose most of the active count. It polls the status word cycle by cycle after a limit write, so a flag raised one cycle early or late shows up directly. It attempts config writes while enabled, limit writes while disabled, and a start from the disabled state, each of which a lax gate would wrongly accept. Random prescale, limit and polarity settings, including compare at or above reload, are checked against active counts measured over whole periods. An off-by-one in the comparison, the period length or the inversion would change those counts.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 3;
  typedef enum logic [ADDR_W-1:0] {
    A_CTRL    = 3'd0,
    A_CFG     = 3'd1,
    A_RELOAD  = 3'd2,
    A_COMPARE = 3'd3,
    A_STATUS  = 3'd4,
    A_CLEAR   = 3'd5
  } lpt_addr_e;
endpackage

// File: rtl/lpt_sync_flag.sv
module lpt_sync_flag #(
  parameter int SYNC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic clr,
  output logic ok
);
  localparam int SW = $clog2(SYNC + 1);
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ok    <= 1'b0;
    end else if (load) begin
      cnt_q <= SW'(SYNC);
      ok    <= 1'b0;
    end else begin
      if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (cnt_q == SW'(1)) ok <= 1'b1;
      else if (clr) ok <= 1'b0;
    end
  end

  p_load_clears_r6: assert property (@(posedge clk) disable iff (rst)
    load |=> !ok);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == SW'(1)) && !load |=> ok);
endmodule

// File: rtl/lpt_regs.sv
module lpt_regs
  import lpt_pkg::*;
#(
  parameter int CW   = 16,
  parameter int PW   = 3,
  parameter int SYNC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              run_o,
  output logic [PW-1:0]     psel_o,
  output logic              pol_o,
  output logic [CW-1:0]     arr_o,
  output logic [CW-1:0]     cmp_o
);
  logic en_q, run_q, pol_q;
  logic [PW-1:0] psel_q;
  logic [CW-1:0] arr_q, cmp_q;
  logic arr_ok, cmp_ok;

  logic wr_ctrl, wr_cfg, wr_arr, wr_cmp, wr_clr;
  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_cfg  = wr_en && (addr == A_CFG);
  assign wr_arr  = wr_en && (addr == A_RELOAD);
  assign wr_cmp  = wr_en && (addr == A_COMPARE);
  assign wr_clr  = wr_en && (addr == A_CLEAR);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      psel_q <= '0;
      pol_q  <= 1'b0;
      arr_q  <= '1;
      cmp_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        run_q <= wdata[0] & (run_q | (wdata[1] & en_q));
      end
      if (wr_cfg && !en_q) begin
        psel_q <= wdata[PW-1:0];
        pol_q  <= wdata[PW];
      end
      if (wr_arr && en_q) arr_q <= wdata;
      if (wr_cmp && en_q) cmp_q <= wdata;
    end
  end

  lpt_sync_flag #(.SYNC(SYNC)) u_cmp_flag (
    .clk(clk), .rst(rst), .load(wr_cmp && en_q), .clr(wr_clr && wdata[0]), .ok(cmp_ok));
  lpt_sync_flag #(.SYNC(SYNC)) u_arr_flag (
    .clk(clk), .rst(rst), .load(wr_arr && en_q), .clr(wr_clr && wdata[1]), .ok(arr_ok));

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (lpt_addr_e'(addr))
        A_CTRL:    rdata <= {{(CW-2){1'b0}}, run_q, en_q};
        A_CFG:     rdata <= {{(CW-PW-1){1'b0}}, pol_q, psel_q};
        A_RELOAD:  rdata <= arr_q;
        A_COMPARE: rdata <= cmp_q;
        A_STATUS:  rdata <= {{(CW-2){1'b0}}, arr_ok, cmp_ok};
        default:   rdata <= '0;
      endcase
    end
  end

  assign run_o  = run_q;
  assign psel_o = psel_q;
  assign pol_o  = pol_q;
  assign arr_o  = arr_q;
  assign cmp_o  = cmp_q;

  p_cfg_lock_r3: assert property (@(posedge clk) disable iff (rst)
    en_q && wr_cfg |=> $stable(psel_q) && $stable(pol_q));
  p_limit_lock_r4: assert property (@(posedge clk) disable iff (rst)
    !en_q && (wr_arr || wr_cmp) |=> $stable(arr_q) && $stable(cmp_q));
  p_stop_r8: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl && (wdata == '0) |=> !en_q && !run_q);
  p_run_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    run_q |-> en_q);
endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] psel,
  output logic          tick
);
  localparam int PCW = (1 << PW) - 1;
  logic [PCW-1:0] pcnt_q, mask;

  always_comb begin
    for (int i = 0; i < PCW; i++) mask[i] = (i < int'(psel));
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt_q <= '0;
    else             pcnt_q <= pcnt_q + 1'b1;
  end

  assign tick = run && ((pcnt_q & mask) == mask);

  p_tick_rate_r2: assert property (@(posedge clk) disable iff (rst)
    tick && (psel != '0) && $stable(run) |=> !tick);
endmodule

// File: rtl/lpt_wave.sv
module lpt_wave #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          tick,
  input  logic          pol,
  input  logic [CW-1:0] arr_sh,
  input  logic [CW-1:0] cmp_sh,
  output logic          pwm_q
);
  logic [CW-1:0] cnt_q, arr_a, cmp_a;
  logic wrap;
  assign wrap = tick && (cnt_q == arr_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      arr_a <= '1;
      cmp_a <= '0;
      pwm_q <= 1'b0;
    end else begin
      if (!run || wrap) begin
        cnt_q <= '0;
        arr_a <= arr_sh;
        cmp_a <= cmp_sh;
      end else if (tick) begin
        cnt_q <= cnt_q + 1'b1;
      end
      pwm_q <= run ? ((cnt_q > cmp_a) ^ pol) : pol;
    end
  end

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> cnt_q <= arr_a);
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    run && wrap |=> cnt_q == '0);
  p_hold_limits_r10: assert property (@(posedge clk) disable iff (rst)
    run && !wrap |=> $stable(arr_a) && $stable(cmp_a));
  p_idle_level_r9: assert property (@(posedge clk) disable iff (rst)
    !run |=> pwm_q == $past(pol));
endmodule

// File: rtl/lpt_pwm_timer.sv
module lpt_pwm_timer
  import lpt_pkg::*;
#(
  parameter int CW   = 16,
  parameter int PW   = 3,
  parameter int SYNC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CW-1:0]     wdata,
  output logic [CW-1:0]     rdata,
  output logic              pwm_out
);
  logic          run, pol, tick;
  logic [PW-1:0] psel;
  logic [CW-1:0] arr_sh, cmp_sh;

  lpt_regs #(.CW(CW), .PW(PW), .SYNC(SYNC)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .run_o(run), .psel_o(psel), .pol_o(pol),
    .arr_o(arr_sh), .cmp_o(cmp_sh));

  lpt_prescaler #(.PW(PW)) u_presc (
    .clk(clk), .rst(rst), .run(run), .psel(psel), .tick(tick));

  lpt_wave #(.CW(CW)) u_wave (
    .clk(clk), .rst(rst), .run(run), .tick(tick), .pol(pol),
    .arr_sh(arr_sh), .cmp_sh(cmp_sh), .pwm_q(pwm_out));

  p_reset_out_r1: assert property (@(posedge clk) $past(rst) |-> !pwm_out);
endmodule

// File: tb/sim_lpt_pwm_timer.sv
`timescale 1ns/1ps
module sim_lpt_pwm_timer;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic pwm_out;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  lpt_pwm_timer u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); addr = a;
    @(negedge clk); d = int'(rdata);
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); h += int'(pwm_out);
    end
  endtask

  function automatic int exp_high(int arr, int cmp, int ps, bit pol, int periods);
    int per, act;
    per = (arr + 1) << ps;
    act = (cmp < arr) ? ((arr - cmp) << ps) : 0;
    return periods * (pol ? per - act : act);
  endfunction

  initial begin
    int v, h;
    int s1 [1:6];
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pwm", int'(pwm_out), 0);
    rd(3'd2, v); check("R1 reload", v, 16'hFFFF);
    rd(3'd3, v); check("R1 compare", v, 0);
    rd(3'd1, v); check("R1 config", v, 0);
    rd(3'd4, v); check("R1 status", v, 0);
    rd(3'd0, v); check("R1 control", v, 0);
    // R4 limit writes ignored while disabled
    wr(3'd2, 16'd5); wr(3'd3, 16'd7);
    rd(3'd2, v); check("R4 reload", v, 16'hFFFF);
    rd(3'd3, v); check("R4 compare", v, 0);
    repeat (4) @(negedge clk);
    rd(3'd4, v); check("R4 status", v, 0);
    // R3 config ignored while enabled
    wr(3'd0, 16'd1);
    wr(3'd1, 16'hA);
    rd(3'd1, v); check("R3 config locked", v, 0);
    wr(3'd0, 16'd0);
    wr(3'd1, 16'h9);
    rd(3'd1, v); check("R3 config accepted", v, 9);
    repeat (2) @(negedge clk);
    check("R9 idle level pol1", int'(pwm_out), 1);
    // R6 flag timing
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd9);
    addr = 3'd4;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk); s1[i] = int'(rdata[1]);
    end
    check("R6 reload ok not yet at read 3", s1[3], 0);
    check("R6 reload ok at read 4", s1[4], 1);
    rd(3'd2, v); check("R4 reload accepted when enabled", v, 9);
    // R7 clear
    wr(3'd5, 16'd2);
    rd(3'd4, v); check("R7 clear reload ok", v, 0);
    wr(3'd3, 16'd3);
    repeat (5) @(negedge clk);
    rd(3'd4, v); check("R6 compare ok", v, 1);
    wr(3'd5, 16'd1);
    rd(3'd4, v); check("R7 clear compare ok", v, 0);
    // R8 start rules
    wr(3'd0, 16'd0);
    wr(3'd0, 16'd3);
    rd(3'd0, v); check("R8 start from disabled ignored", v, 1);
    wr(3'd0, 16'd3);
    rd(3'd0, v); check("R8 start while enabled", v, 3);
    // R5/R9: psel1 pol1 reload9 compare3 -> period 20, active 12 cycles (low)
    repeat (4) @(negedge clk);
    count_high(40, h); check("R5 R9 inverted duty", h, exp_high(9, 3, 1, 1'b1, 2));
    // R8 stop
    wr(3'd0, 16'd0);
    repeat (2) @(negedge clk);
    count_high(10, h); check("R8 R9 stopped holds inactive", h, 10);
    rd(3'd0, v); check("R8 control cleared", v, 0);
    // R10 staged limit
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd99);
    wr(3'd3, 16'd49);
    wr(3'd0, 16'd3);
    fork
      count_high(100, h);
      begin repeat (6) @(negedge clk); wr(3'd2, 16'd60); end
    join
    check("R10 first period keeps old reload", h, 50);
    count_high(61, h); check("R10 new reload after wrap", h, exp_high(60, 49, 0, 1'b0, 1));
    wr(3'd3, 16'd70);
    repeat (70) @(negedge clk);
    count_high(61, h); check("R5 compare above reload", h, 0);
    // R2/R5/R9 random settings
    for (int k = 0; k < 10; k++) begin
      int ps, ar, cm, per;
      bit pl;
      ps = int'($urandom % 4);
      ar = 1 + int'($urandom % 20);
      cm = int'($urandom % (ar + 3));
      pl = 1'($urandom % 2);
      per = (ar + 1) << ps;
      wr(3'd0, 16'd0);
      wr(3'd1, 16'((int'(pl) << 3) | ps));
      wr(3'd0, 16'd1);
      wr(3'd2, 16'(ar));
      wr(3'd3, 16'(cm));
      wr(3'd0, 16'd3);
      repeat (4) @(negedge clk);
      count_high(2 * per, h);
      check("R2 R5 R9 random duty", h, exp_high(ar, cm, ps, pl, 2));
    end
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule